// File: doc/BRIEF.md
# Data TLB Store-Miss Trap Entry

This block sits beside the data translation lookup of a processor's load/store pipeline. Each cycle it receives at most one memory access together with the translation lookup result for that access. A store or cache-maintenance access must trap into a software page-table-walk handler in two cases: its effective address found no translation, or it hit a translation whose changed flag is still clear. In the second case software must set the flag before the store may proceed. Loads never trap here.

When it traps, the block records the architectural exception-entry state. SRR0 receives the next-instruction address of the interrupted program. SRR1 receives a masked copy of the machine state word. A new machine state word is built for the handler, with translation, interrupts and privilege dropped. It also issues a fetch redirect to the handler vector and holds it until the fetch unit accepts it. While that redirect is outstanding, no further store commits and no further trap is raised.

Bit positions of the machine state word are numbered big-endian: architectural bit k is vector bit 31-k. The architectural positions are TGPR=14, ILE=15, ME=19, IP=25 and LE=31.

Top module: `dstore_trap_entry`

## Requirements
- R1: A valid store access (`acc_valid`=1, `acc_is_store`=1) with `tlb_hit`=0, accepted while no redirect is outstanding, raises `trap_pulse` on the cycle after the access.
- R2: A valid store with `tlb_hit`=1 and `tlb_chg`=0 also traps as in R1. A valid store with `tlb_hit`=1 and `tlb_chg`=1 does not trap.
- R3: A load access (`acc_is_store`=0) never traps and leaves all registered outputs unchanged, whatever the lookup result.
- R4: `trap_pulse` is high for exactly one cycle per accepted faulting store.
- R5: `store_commit` is high, in the same cycle, only for a valid store that hits with `tlb_chg`=1 while no redirect is outstanding. A faulting store never commits.
- R6: While `redir_valid` is high, no new trap is raised and `srr0`, `srr1`, `msr_out` and `redir_addr` hold their values.
- R7: `redir_valid` rises together with `trap_pulse` and stays high until the cycle after `redir_ack` is sampled high.
- R8: `redir_addr` is 0xFFF01200 when IP of the interrupted state was 1, otherwise 0x00001200.
- R9: On a trap, `srr0` takes the `nia` value presented with the faulting store.
- R10: On a trap, `srr1` takes `msr_in` bits 15:0 in its bits 15:0, with bits 31:16 cleared.
- R11: On a trap, `msr_out` keeps ILE, ME and IP from `msr_in`, sets TGPR to 1, sets LE to the old ILE, and clears every other bit.
- R12: After synchronous reset, `trap_pulse`, `redir_valid`, `srr0`, `srr1`, `msr_out` and `redir_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_is_store | input | 1 | 1 = store or cache operation, 0 = load |
| tlb_hit | input | 1 | Translation lookup hit |
| tlb_chg | input | 1 | Changed flag of the hitting entry |
| msr_in | input | 32 | Current machine state word |
| nia | input | 32 | Next-instruction address of the program |
| redir_ack | input | 1 | Fetch unit accepts the redirect |
| store_commit | output | 1 | The presented store may be committed |
| trap_pulse | output | 1 | One-cycle exception strobe |
| srr0 | output | 32 | Saved return address |
| srr1 | output | 32 | Saved masked machine state |
| msr_out | output | 32 | Machine state word for the handler |
| redir_addr | output | 32 | Handler fetch address |
| redir_valid | output | 1 | Redirect outstanding |

## Verification
`store_commit` is combinational and due in the same cycle as the access. The bench drives an access just after a falling edge and samples the commit 1 ns later. `trap_pulse`, the saved registers, the handler state word and the redirect are due one rising edge after the access, so the bench samples them at the following falling edge. Acknowledge takes effect at the same rising edge and is checked at that same falling edge. A reference model in the bench advances once per rising edge, which keeps every comparison aligned to exactly one register stage.

// File: rtl/dste_pkg.sv
package dste_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    // machine state bit positions (architectural big-endian index k -> WORD_W-1-k)
    localparam int B_TGPR = WORD_W - 1 - 14;
    localparam int B_ILE  = WORD_W - 1 - 15;
    localparam int B_ME   = WORD_W - 1 - 19;
    localparam int B_IP   = WORD_W - 1 - 25;
    localparam int B_LE   = WORD_W - 1 - 31;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        FC_NONE  = 2'd0,
        FC_MISS  = 2'd1,
        FC_CLEAN = 2'd2
    } fault_cause_e;

    typedef struct packed {
        word_t srr0;
        word_t srr1;
        word_t msr;
        word_t vec;
    } entry_frame_t;

    function automatic word_t save_state(input word_t m);
        return {{HALF_W{1'b0}}, m[HALF_W-1:0]};
    endfunction

    function automatic word_t handler_state(input word_t m);
        word_t r;
        r         = '0;
        r[B_ILE]  = m[B_ILE];
        r[B_ME]   = m[B_ME];
        r[B_IP]   = m[B_IP];
        r[B_TGPR] = 1'b1;
        r[B_LE]   = m[B_ILE];
        return r;
    endfunction

endpackage

// File: rtl/dste_detect.sv
module dste_detect
    import dste_pkg::*;
(
    input  logic         acc_valid,
    input  logic         acc_is_store,
    input  logic         tlb_hit,
    input  logic         tlb_chg,
    input  logic         busy,
    output fault_cause_e cause,
    output logic         take,
    output logic         commit
);
    logic st_req;

    always_comb begin
        st_req = acc_valid && acc_is_store;
        if (!st_req)
            cause = FC_NONE;
        else if (!tlb_hit)
            cause = FC_MISS;
        else if (!tlb_chg)
            cause = FC_CLEAN;
        else
            cause = FC_NONE;
        take   = (cause != FC_NONE) && !busy;
        commit = st_req && (cause == FC_NONE) && !busy;
    end
endmodule

// File: rtl/dste_frame.sv
module dste_frame
    import dste_pkg::*;
#(
    parameter word_t VEC_OFFSET = 32'h0000_1200,
    parameter word_t HIGH_BASE  = 32'hFFF0_0000
) (
    input  word_t        msr_in,
    input  word_t        nia,
    output entry_frame_t frame
);
    word_t base;

    always_comb begin
        base       = msr_in[B_IP] ? HIGH_BASE : '0;
        frame.srr0 = nia;
        frame.srr1 = save_state(msr_in);
        frame.msr  = handler_state(msr_in);
        frame.vec  = base | VEC_OFFSET;
    end
endmodule

// File: rtl/dste_hold.sv
module dste_hold
    import dste_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         take,
    input  entry_frame_t frame,
    input  logic         ack,
    output logic         pulse,
    output logic         pending,
    output entry_frame_t frame_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse   <= 1'b0;
            pending <= 1'b0;
            frame_q <= '0;
        end else begin
            pulse <= take;
            if (take) begin
                pending <= 1'b1;
                frame_q <= frame;
            end else if (pending && ack) begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dstore_trap_entry.sv
module dstore_trap_entry
    import dste_pkg::*;
#(
    parameter word_t VEC_OFFSET = 32'h0000_1200,
    parameter word_t HIGH_BASE  = 32'hFFF0_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic        acc_is_store,
    input  logic        tlb_hit,
    input  logic        tlb_chg,
    input  logic [31:0] msr_in,
    input  logic [31:0] nia,
    input  logic        redir_ack,
    output logic        store_commit,
    output logic        trap_pulse,
    output logic [31:0] srr0,
    output logic [31:0] srr1,
    output logic [31:0] msr_out,
    output logic [31:0] redir_addr,
    output logic        redir_valid
);
    fault_cause_e cause;
    logic         take;
    entry_frame_t frame_d;
    entry_frame_t frame_q;

    dste_detect u_detect (
        .acc_valid   (acc_valid),
        .acc_is_store(acc_is_store),
        .tlb_hit     (tlb_hit),
        .tlb_chg     (tlb_chg),
        .busy        (redir_valid),
        .cause       (cause),
        .take        (take),
        .commit      (store_commit)
    );

    dste_frame #(
        .VEC_OFFSET(VEC_OFFSET),
        .HIGH_BASE (HIGH_BASE)
    ) u_frame (
        .msr_in(msr_in),
        .nia   (nia),
        .frame (frame_d)
    );

    dste_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .frame  (frame_d),
        .ack    (redir_ack),
        .pulse  (trap_pulse),
        .pending(redir_valid),
        .frame_q(frame_q)
    );

    assign srr0       = frame_q.srr0;
    assign srr1       = frame_q.srr1;
    assign msr_out    = frame_q.msr;
    assign redir_addr = frame_q.vec;
endmodule

// File: rtl/dste_checker.sv
module dste_checker
    import dste_pkg::*;
#(
    parameter word_t VEC_OFFSET = 32'h0000_1200,
    parameter word_t HIGH_BASE  = 32'hFFF0_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic        acc_is_store,
    input logic        tlb_hit,
    input logic        tlb_chg,
    input logic        redir_ack,
    input logic        store_commit,
    input logic        trap_pulse,
    input logic [31:0] srr0,
    input logic [31:0] srr1,
    input logic [31:0] msr_out,
    input logic [31:0] redir_addr,
    input logic        redir_valid
);
    a_r1_miss_traps: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_is_store && !tlb_hit && !redir_valid |=> trap_pulse);

    a_r2_clean_traps: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_is_store && tlb_hit && !tlb_chg && !redir_valid |=> trap_pulse);

    a_r3_load_quiet: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_is_store |=> !trap_pulse);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |=> !trap_pulse);

    a_r5_no_commit_on_fault: assert property (@(posedge clk) disable iff (rst)
        (!tlb_hit || !tlb_chg || redir_valid) |-> !store_commit);

    a_r6_no_retrap: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> !trap_pulse);

    a_r6_frame_holds: assert property (@(posedge clk) disable iff (rst)
        redir_valid && !trap_pulse |-> $stable(srr0) && $stable(srr1) && $stable(msr_out));

    a_r7_held_until_ack: assert property (@(posedge clk) disable iff (rst)
        redir_valid && !redir_ack |=> redir_valid);

    a_r7_rise_with_pulse: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |-> redir_valid);

    a_r8_vector: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> redir_addr == ((msr_out[B_IP] ? HIGH_BASE : 32'h0) | VEC_OFFSET));

    a_r11_le_from_ile: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> msr_out[B_LE] == msr_out[B_ILE] && msr_out[B_TGPR]);
endmodule

bind dstore_trap_entry dste_checker #(
    .VEC_OFFSET(VEC_OFFSET),
    .HIGH_BASE (HIGH_BASE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_is_store(acc_is_store),
    .tlb_hit     (tlb_hit),
    .tlb_chg     (tlb_chg),
    .redir_ack   (redir_ack),
    .store_commit(store_commit),
    .trap_pulse  (trap_pulse),
    .srr0        (srr0),
    .srr1        (srr1),
    .msr_out     (msr_out),
    .redir_addr  (redir_addr),
    .redir_valid (redir_valid)
);

// File: tb/tb_dstore_trap_entry.sv
`timescale 1ns/1ps
module tb_dstore_trap_entry;
    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, acc_is_store, tlb_hit, tlb_chg, redir_ack;
    logic [31:0] msr_in, nia;
    logic        store_commit, trap_pulse, redir_valid;
    logic [31:0] srr0, srr1, msr_out, redir_addr;

    int errors = 0;
    int checks = 0;

    // model state
    logic        m_pulse, m_pend;
    logic [31:0] m_srr0, m_srr1, m_msr, m_vec;
    string       m_tag;

    always #10 clk = ~clk;

    dstore_trap_entry dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_is_store(acc_is_store),
        .tlb_hit(tlb_hit), .tlb_chg(tlb_chg), .msr_in(msr_in), .nia(nia),
        .redir_ack(redir_ack), .store_commit(store_commit), .trap_pulse(trap_pulse),
        .srr0(srr0), .srr1(srr1), .msr_out(msr_out), .redir_addr(redir_addr),
        .redir_valid(redir_valid)
    );

    function automatic int pos(input int be);
        return 31 - be;
    endfunction

    function automatic logic [31:0] f_srr1(input logic [31:0] m);
        return m & 32'h0000_FFFF;
    endfunction

    function automatic logic [31:0] f_msr(input logic [31:0] m);
        logic [31:0] r = 32'h0;
        r[pos(15)] = m[pos(15)];
        r[pos(19)] = m[pos(19)];
        r[pos(25)] = m[pos(25)];
        r[pos(14)] = 1'b1;
        r[pos(31)] = m[pos(15)];
        return r;
    endfunction

    function automatic logic [31:0] f_vec(input logic [31:0] m);
        return m[pos(25)] ? 32'hFFF0_1200 : 32'h0000_1200;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: drive at a falling edge, check commit, then check registered results
    task automatic step(input logic v, input logic st, input logic hit, input logic chg,
                        input logic [31:0] m, input logic [31:0] a, input logic ak);
        logic fault, take;
        acc_valid = v; acc_is_store = st; tlb_hit = hit; tlb_chg = chg;
        msr_in = m; nia = a; redir_ack = ak;
        fault = v && st && (!hit || !chg);
        take  = fault && !m_pend;
        #1;
        chk("R5 store_commit", {31'b0, store_commit},
            {31'b0, v && st && hit && chg && !m_pend});
        if (!v || !st)            m_tag = "R3";
        else if (fault && m_pend) m_tag = "R6";
        else if (!hit)            m_tag = "R1";
        else if (!chg)            m_tag = "R2";
        else                      m_tag = "R4";
        m_pulse = take;
        if (take) begin
            m_pend = 1'b1;
            m_srr0 = a; m_srr1 = f_srr1(m); m_msr = f_msr(m); m_vec = f_vec(m);
        end else if (m_pend && ak) begin
            m_pend = 1'b0;
        end
        @(negedge clk);
        chk({m_tag, " trap_pulse"}, {31'b0, trap_pulse}, {31'b0, m_pulse});
        chk("R7 redir_valid", {31'b0, redir_valid}, {31'b0, m_pend});
        chk("R9 srr0", srr0, m_srr0);
        chk("R10 srr1", srr1, m_srr1);
        chk("R11 msr_out", msr_out, m_msr);
        chk("R8 redir_addr", redir_addr, m_vec);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst = 1'b1;
        acc_valid = 0; acc_is_store = 0; tlb_hit = 0; tlb_chg = 0;
        msr_in = 0; nia = 0; redir_ack = 0;
        m_pulse = 0; m_pend = 0; m_srr0 = 0; m_srr1 = 0; m_msr = 0; m_vec = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 trap_pulse", {31'b0, trap_pulse}, 32'h0);
        chk("R12 redir_valid", {31'b0, redir_valid}, 32'h0);
        chk("R12 srr0", srr0, 32'h0);
        chk("R12 srr1", srr1, 32'h0);
        chk("R12 msr_out", msr_out, 32'h0);
        chk("R12 redir_addr", redir_addr, 32'h0);
        rst = 1'b0;

        // R1: miss with IP=1 and all bits set, high vector
        step(1, 1, 0, 0, 32'hFFFF_FFFF, 32'h1000_0004, 0);
        // R6: another fault while pending is blocked
        step(1, 1, 0, 1, 32'h0000_0000, 32'h2222_2220, 0);
        // R4: pulse gone, R7 still held
        step(0, 0, 0, 0, 32'h0, 32'h0, 0);
        // R7: acknowledge
        step(0, 0, 0, 0, 32'h0, 32'h0, 1);
        // R3: load miss does not trap
        step(1, 0, 0, 0, 32'h1234_5678, 32'h3333_3330, 0);
        // R2: clean hit traps, IP=0 low vector, ILE=1 -> LE=1
        step(1, 1, 1, 0, 32'h0001_A5A5 & ~32'h0000_0040, 32'h4444_4440, 0);
        step(0, 0, 0, 0, 32'h0, 32'h0, 1);
        // R5: dirty hit commits, no trap
        step(1, 1, 1, 1, 32'hFFFF_FFFF, 32'h5555_5550, 0);
        // R5: commit blocked while pending
        step(1, 1, 0, 0, 32'h0000_0040, 32'h6666_6660, 0);
        step(1, 1, 1, 1, 32'h0, 32'h7777_7770, 0);
        step(0, 0, 0, 0, 32'h0, 32'h0, 1);

        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
                 $urandom, $urandom & 32'hFFFF_FFFC, ($urandom % 3) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule